// File: doc/BRIEF.md
# Twin-Port Synchronous RAM Core

This block is a static memory with two fully independent ports. Each port has its own clock, address, write data, read/write strobe, output enable and a read-timing mode input. Each port also has a pair of chip enables of opposite polarity. Either port may read or write any word at any time, and the two ports do not coordinate. Address, enables, strobe and write data are captured on the rising edge of the port's own clock.

A read captured on an edge is presented either just after that edge (flow-through) or one edge later from an output register (pipelined). The mode input of each port picks the timing. The output is modelled as a data bus plus a drive flag in place of a tri-state pin. The drive flag follows the controls captured on earlier edges, gated at once by the output enable. Whenever the flag is low, the bus reads all zeros.

Storage is split into one bank per writing port and a per-word ownership flag pair, so that each clock domain writes only its own state. The address width and the data width are parameters. The contents of the array are not initialised.

Top module: `twin_port_sram`

## Requirements
- R1: A port is selected on an edge only when its active-low enable is 0 and its active-high enable is 1 on that edge. With any other enable pair, the edge neither writes the array nor produces read data.
- R2: A selected edge with the read/write strobe at 0 stores the write data at the captured address.
- R3: With the mode input at 1 (pipelined), data read on edge E is driven after edge E+1, but only if the port is also selected on E+1. This holds even when E+1 is a write.
- R4: With the mode input at 0 (flow-through), a selected edge with the strobe at 1 drives the word at the captured address right after that edge.
- R5: In both modes, an edge on which the port is not selected leaves the output undriven after that edge.
- R6: Output enable at 1 drops the drive flag at once, without waiting for a clock. Returning it to 0 restores the drive that the registered state calls for.
- R7: In flow-through mode, a write edge leaves the output undriven after that edge.
- R8: A word written on one port is returned by a read on the other port from that port's first capture edge strictly after the write edge. A read on the same edge as the write returns the earlier contents.
- R9: Accesses to different addresses on the same edge, one on each port, both take effect.
- R10: When both ports write the same address on the same edge, the stored word is one of the two written values. Which one is not defined.
- R11: While reset is 0 on an edge, the port's drive flag is 0 and its bus is zero after that edge. Reset leaves the array contents unchanged.
- R12: The data bus is all zeros whenever the drive flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Port A clock |
| a_rst_n | input | 1 | Port A synchronous active-low reset of the output state |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_we_n | input | 1 | Port A strobe: 0 write, 1 read |
| a_ce_lo_n | input | 1 | Port A enable, active low |
| a_ce_hi | input | 1 | Port A enable, active high |
| a_oe_n | input | 1 | Port A output enable, active low, asynchronous |
| a_pipe | input | 1 | Port A mode: 0 flow-through, 1 pipelined |
| a_dout | output | DATA_W | Port A read data, zero when not driven |
| a_drive | output | 1 | Port A output drive flag |
| b_clk | input | 1 | Port B clock |
| b_rst_n | input | 1 | Port B synchronous active-low reset of the output state |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_we_n | input | 1 | Port B strobe: 0 write, 1 read |
| b_ce_lo_n | input | 1 | Port B enable, active low |
| b_ce_hi | input | 1 | Port B enable, active high |
| b_oe_n | input | 1 | Port B output enable, active low, asynchronous |
| b_pipe | input | 1 | Port B mode: 0 flow-through, 1 pipelined |
| b_dout | output | DATA_W | Port B read data, zero when not driven |
| b_drive | output | 1 | Port B output drive flag |

## Verification
A write on one port and an access to the same word on the other port can land on the same edge. The bench runs both ports from one clock so that this happens on purpose.

For a write against a read on that edge, the read must return the old word. The next read edge must return the new word. For a write against a write to one address, the read-back is accepted if it equals either written value or is unknown. For writes to two different addresses on one edge, both words must read back exactly.

// File: rtl/tps_pkg.sv
// Shared definitions for the twin-port RAM.
// Assumes: enable pins are sampled as plain logic levels; no tri-state modelling.
package tps_pkg;

    // Read-timing choice carried on each port's mode pin.
    typedef enum logic {
        MODE_FLOW = 1'b0,
        MODE_PIPE = 1'b1
    } rd_mode_e;

    // A port is selected only with the low enable at 0 and the high enable at 1.
    function automatic logic port_selected(input logic ce_lo_n, input logic ce_hi);
        return (~ce_lo_n) & ce_hi;
    endfunction

endpackage

// File: rtl/tps_bank_array.sv
// Two-writer storage for the twin-port RAM.
// Each writer owns one data bank and one ownership flag array, so every piece of
// state is written from a single clock domain. The flags mark which bank holds the
// latest copy of a word: equal flags point at bank A, different flags at bank B.
// Assumes: reads are combinational on the presented address; the calling port
// registers the result. Contents are not initialised.
module tps_bank_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 9
) (
    input  logic              clk_a,
    input  logic              we_a,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [DATA_W-1:0] wdata_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic              clk_b,
    input  logic              we_b,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic [DATA_W-1:0] wdata_b,
    output logic [DATA_W-1:0] rdata_b
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] bank_a [DEPTH];
    logic [DATA_W-1:0] bank_b [DEPTH];
    logic              own_a  [DEPTH];
    logic              own_b  [DEPTH];

    // Port A write: store the word and make the flags agree (bank A is newest).
    always_ff @(posedge clk_a) begin
        if (we_a) begin
            bank_a[addr_a] <= wdata_a;
            own_a[addr_a]  <= own_b[addr_a];
        end
    end

    // Port B write: store the word and make the flags differ (bank B is newest).
    always_ff @(posedge clk_b) begin
        if (we_b) begin
            bank_b[addr_b] <= wdata_b;
            own_b[addr_b]  <= ~own_a[addr_b];
        end
    end

    // Read selection for both ports: pick the bank the flag pair points at.
    always_comb begin
        rdata_a = (own_a[addr_a] ^ own_b[addr_a]) ? bank_b[addr_a] : bank_a[addr_a];
        rdata_b = (own_a[addr_b] ^ own_b[addr_b]) ? bank_b[addr_b] : bank_a[addr_b];
    end

endmodule

// File: rtl/tps_port.sv
// One access port of the twin-port RAM.
// Decodes the enable pair, issues writes to the array and stages read data through
// a flow-through register and a pipelined register. The drive flag is built from
// registered state and gated asynchronously by output enable.
// Assumes: the mode pin is held steady while reads are in flight; reset is
// synchronous, active low, and clears only the output state.
module tps_port #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we_n,
    input  logic              ce_lo_n,
    input  logic              ce_hi,
    input  logic              oe_n,
    input  logic              pipe_mode,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] dout,
    output logic              drive
);
    import tps_pkg::*;

    logic              sel;
    logic              rd_req;
    logic              ft_vld;
    logic [DATA_W-1:0] ft_q;
    logic              pp_vld;
    logic [DATA_W-1:0] pp_q;
    logic              stage_vld;
    logic [DATA_W-1:0] stage_q;
    rd_mode_e          mode;

    // Decode selection and the kind of access requested on this edge.
    always_comb begin
        sel       = port_selected(ce_lo_n, ce_hi);
        rd_req    = sel & we_n;
        mem_we    = sel & ~we_n;
        mem_addr  = addr;
        mem_wdata = wdata;
        mode      = rd_mode_e'(pipe_mode);
    end

    // Flow-through stage: capture the addressed word on a selected read edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ft_vld <= 1'b0;
            ft_q   <= '0;
        end else begin
            ft_vld <= rd_req;
            if (rd_req) begin
                ft_q <= mem_rdata;
            end
        end
    end

    // Pipelined stage: pass last edge's read on, driven only if still selected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pp_vld <= 1'b0;
            pp_q   <= '0;
        end else begin
            pp_vld <= ft_vld & sel;
            if (ft_vld) begin
                pp_q <= ft_q;
            end
        end
    end

    // Output choice by mode, asynchronous output enable, zero bus when idle.
    always_comb begin
        stage_vld = (mode == MODE_PIPE) ? pp_vld : ft_vld;
        stage_q   = (mode == MODE_PIPE) ? pp_q   : ft_q;
        drive     = stage_vld & ~oe_n;
        dout      = drive ? stage_q : '0;
    end

    // R5: an unselected edge leaves the output undriven after it.
    a_r5_desel_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !drive);

    // R7: a flow-through write edge is followed by an undriven output.
    a_r7_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !pipe_mode) |=> (pipe_mode || !drive));

    // R3: pipelined drive needs a read two edges back and selection one edge back.
    a_r3_pipe_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && drive) |-> ($past(rd_req, 2) && $past(sel)));

    // R11: reset leaves the port undriven with a zero bus.
    a_r11_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!drive && dout == '0));

endmodule

// File: rtl/twin_port_sram.sv
// Twin-port synchronous RAM top level.
// Two independent ports, each on its own clock, share one storage array. Each
// port chooses flow-through or pipelined read timing with its mode pin.
// Assumes: same-address writes on the same edge from both ports leave an
// undefined one of the two values; nothing arbitrates between the ports.
module twin_port_sram #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 9
) (
    input  logic              a_clk,
    input  logic              a_rst_n,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic              a_we_n,
    input  logic              a_ce_lo_n,
    input  logic              a_ce_hi,
    input  logic              a_oe_n,
    input  logic              a_pipe,
    output logic [DATA_W-1:0] a_dout,
    output logic              a_drive,
    input  logic              b_clk,
    input  logic              b_rst_n,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    input  logic              b_we_n,
    input  logic              b_ce_lo_n,
    input  logic              b_ce_hi,
    input  logic              b_oe_n,
    input  logic              b_pipe,
    output logic [DATA_W-1:0] b_dout,
    output logic              b_drive
);
    logic              a_mem_we,    b_mem_we;
    logic [ADDR_W-1:0] a_mem_addr,  b_mem_addr;
    logic [DATA_W-1:0] a_mem_wdata, b_mem_wdata;
    logic [DATA_W-1:0] a_mem_rdata, b_mem_rdata;

    tps_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port_a (
        .clk       (a_clk),
        .rst_n     (a_rst_n),
        .addr      (a_addr),
        .wdata     (a_wdata),
        .we_n      (a_we_n),
        .ce_lo_n   (a_ce_lo_n),
        .ce_hi     (a_ce_hi),
        .oe_n      (a_oe_n),
        .pipe_mode (a_pipe),
        .mem_we    (a_mem_we),
        .mem_addr  (a_mem_addr),
        .mem_wdata (a_mem_wdata),
        .mem_rdata (a_mem_rdata),
        .dout      (a_dout),
        .drive     (a_drive)
    );

    tps_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port_b (
        .clk       (b_clk),
        .rst_n     (b_rst_n),
        .addr      (b_addr),
        .wdata     (b_wdata),
        .we_n      (b_we_n),
        .ce_lo_n   (b_ce_lo_n),
        .ce_hi     (b_ce_hi),
        .oe_n      (b_oe_n),
        .pipe_mode (b_pipe),
        .mem_we    (b_mem_we),
        .mem_addr  (b_mem_addr),
        .mem_wdata (b_mem_wdata),
        .mem_rdata (b_mem_rdata),
        .dout      (b_dout),
        .drive     (b_drive)
    );

    tps_bank_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk_a   (a_clk),
        .we_a    (a_mem_we),
        .addr_a  (a_mem_addr),
        .wdata_a (a_mem_wdata),
        .rdata_a (a_mem_rdata),
        .clk_b   (b_clk),
        .we_b    (b_mem_we),
        .addr_b  (b_mem_addr),
        .wdata_b (b_mem_wdata),
        .rdata_b (b_mem_rdata)
    );

endmodule

// File: tb/twin_port_sram_tb.sv
// Directed bench for the twin-port RAM; both ports share one 100 MHz clock so
// that same-edge cases can be provoked. Inputs change on falling edges and
// outputs are sampled on falling edges.
module twin_port_sram_tb;
    localparam int AW = 10;
    localparam int DW = 9;

    logic          clk = 1'b0;
    logic          a_rst_n, b_rst_n;
    logic [AW-1:0] a_addr, b_addr;
    logic [DW-1:0] a_wdata, b_wdata;
    logic          a_we_n, a_ce_lo_n, a_ce_hi, a_oe_n, a_pipe;
    logic          b_we_n, b_ce_lo_n, b_ce_hi, b_oe_n, b_pipe;
    logic [DW-1:0] a_dout, b_dout;
    logic          a_drive, b_drive;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    twin_port_sram #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .a_clk(clk), .a_rst_n(a_rst_n), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_we_n(a_we_n), .a_ce_lo_n(a_ce_lo_n), .a_ce_hi(a_ce_hi),
        .a_oe_n(a_oe_n), .a_pipe(a_pipe), .a_dout(a_dout), .a_drive(a_drive),
        .b_clk(clk), .b_rst_n(b_rst_n), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_we_n(b_we_n), .b_ce_lo_n(b_ce_lo_n), .b_ce_hi(b_ce_hi),
        .b_oe_n(b_oe_n), .b_pipe(b_pipe), .b_dout(b_dout), .b_drive(b_drive)
    );

    // Compare one value and report a miscompare.
    task automatic chk(input string req, input logic [DW:0] act, input logic [DW:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Advance one clock: the next rising edge captures, sampling at the falling edge.
    task automatic cyc();
        @(negedge clk);
    endtask

    // Port A controls: sel selects with the legal enable pair.
    task automatic set_a(input logic sel, input logic wr, input logic [AW-1:0] ad,
                         input logic [DW-1:0] d);
        a_ce_lo_n = ~sel; a_ce_hi = sel; a_we_n = ~wr; a_addr = ad; a_wdata = d;
    endtask

    task automatic set_b(input logic sel, input logic wr, input logic [AW-1:0] ad,
                         input logic [DW-1:0] d);
        b_ce_lo_n = ~sel; b_ce_hi = sel; b_we_n = ~wr; b_addr = ad; b_wdata = d;
    endtask

    task automatic idle_both();
        set_a(1'b0, 1'b0, '0, '0);
        set_b(1'b0, 1'b0, '0, '0);
    endtask

    // Reset state of both ports (R11, R12).
    task automatic t_reset();
        a_rst_n = 1'b0; b_rst_n = 1'b0;
        a_oe_n = 1'b0; b_oe_n = 1'b0; a_pipe = 1'b0; b_pipe = 1'b0;
        idle_both();
        repeat (3) cyc();
        chk("R11 a drive in reset", {a_drive, a_dout}, '0);
        chk("R11 b drive in reset", {b_drive, b_dout}, '0);
        a_rst_n = 1'b1; b_rst_n = 1'b1;
        cyc();
    endtask

    // Flow-through write then read, then deselect (R2, R4, R5, R12).
    task automatic t_flow_rw();
        set_a(1'b1, 1'b1, 10'd5, 9'h1A5); cyc();
        set_a(1'b1, 1'b0, 10'd5, 9'h000); cyc();
        chk("R4 flow read data", {a_drive, a_dout}, {1'b1, 9'h1A5});
        set_a(1'b0, 1'b0, 10'd5, 9'h000); cyc();
        chk("R5 R12 deselect undriven zero bus", {a_drive, a_dout}, '0);
    endtask

    // Flow-through write cycle is undriven; written word reads back (R7, R2).
    task automatic t_write_quiet();
        set_a(1'b1, 1'b0, 10'd5, 9'h000); cyc();
        set_a(1'b1, 1'b1, 10'd6, 9'h0C3); cyc();
        chk("R7 write edge undriven", {a_drive, a_dout}, '0);
        set_a(1'b1, 1'b0, 10'd6, 9'h000); cyc();
        chk("R2 write stored", {a_drive, a_dout}, {1'b1, 9'h0C3});
        set_a(1'b0, 1'b0, '0, '0); cyc();
    endtask

    // Output enable acts without a clock (R6).
    task automatic t_oe();
        a_oe_n = 1'b1;
        set_a(1'b1, 1'b0, 10'd5, 9'h000); cyc();
        chk("R6 oe high undriven", {a_drive, a_dout}, '0);
        #1 a_oe_n = 1'b0;
        #1 chk("R6 oe low restores drive", {a_drive, a_dout}, {1'b1, 9'h1A5});
        set_a(1'b0, 1'b0, '0, '0); cyc();
    endtask

    // Illegal enable pairs neither write nor read (R1).
    task automatic t_select();
        set_a(1'b1, 1'b1, 10'd7, 9'h055); cyc();
        a_ce_lo_n = 1'b0; a_ce_hi = 1'b0; a_we_n = 1'b0; a_wdata = 9'h1FF; cyc();
        a_ce_lo_n = 1'b1; a_ce_hi = 1'b1; a_we_n = 1'b0; a_wdata = 9'h1EE; cyc();
        a_we_n = 1'b1; cyc();
        chk("R1 read with both enables high", {a_drive, a_dout}, '0);
        set_a(1'b1, 1'b0, 10'd7, 9'h000); cyc();
        chk("R1 unselected writes ignored", {a_drive, a_dout}, {1'b1, 9'h055});
        set_a(1'b0, 1'b0, '0, '0); cyc();
    endtask

    // Pipelined timing on port B, reading words written through port A (R3, R5, R8).
    task automatic t_pipe();
        b_pipe = 1'b1; cyc();
        set_b(1'b1, 1'b0, 10'd5, 9'h000); cyc();
        chk("R3 pipe not yet driven", {b_drive, b_dout}, '0);
        set_b(1'b1, 1'b0, 10'd6, 9'h000); cyc();
        chk("R3 R8 pipe data one edge later", {b_drive, b_dout}, {1'b1, 9'h1A5});
        set_b(1'b0, 1'b0, '0, '0); cyc();
        chk("R5 pipe deselect drops pending read", {b_drive, b_dout}, '0);
        set_b(1'b1, 1'b0, 10'd5, 9'h000); cyc();
        set_b(1'b1, 1'b1, 10'd8, 9'h0AA); cyc();
        chk("R3 pipe data during write edge", {b_drive, b_dout}, {1'b1, 9'h1A5});
        set_b(1'b0, 1'b0, '0, '0); cyc(); cyc();
        b_pipe = 1'b0; cyc();
    endtask

    // Write on A against read on B at the same and the next edge (R8).
    task automatic t_cross();
        set_a(1'b1, 1'b1, 10'd9, 9'h011); cyc();
        set_a(1'b1, 1'b1, 10'd9, 9'h122);
        set_b(1'b1, 1'b0, 10'd9, 9'h000); cyc();
        chk("R8 same-edge read sees old word", {b_drive, b_dout}, {1'b1, 9'h011});
        set_a(1'b0, 1'b0, '0, '0); cyc();
        chk("R8 next-edge read sees new word", {b_drive, b_dout}, {1'b1, 9'h122});
        idle_both(); cyc();
    endtask

    // Both ports write different words on one edge, then cross-read (R9).
    task automatic t_parallel();
        set_a(1'b1, 1'b1, 10'd20, 9'h0F0);
        set_b(1'b1, 1'b1, 10'd21, 9'h10F); cyc();
        set_a(1'b1, 1'b0, 10'd21, 9'h000);
        set_b(1'b1, 1'b0, 10'd20, 9'h000); cyc();
        chk("R9 a reads b's word", {a_drive, a_dout}, {1'b1, 9'h10F});
        chk("R9 b reads a's word", {b_drive, b_dout}, {1'b1, 9'h0F0});
        idle_both(); cyc();
    endtask

    // Same-address same-edge writes: accept either value or unknown (R10).
    task automatic t_collide();
        logic [DW-1:0] got;
        set_a(1'b1, 1'b1, 10'd30, 9'h0AB);
        set_b(1'b1, 1'b1, 10'd30, 9'h154); cyc();
        set_b(1'b0, 1'b0, '0, '0);
        set_a(1'b1, 1'b0, 10'd30, 9'h000); cyc();
        got = a_dout;
        n_checks++;
        if (!(got === 9'h0AB || got === 9'h154 || $isunknown(got))) begin
            n_fails++;
            $display("FAIL R10 collision: actual %h expected %h or %h", got, 9'h0AB, 9'h154);
        end
        idle_both(); cyc();
    endtask

    // A second reset clears output state but not the array (R11).
    task automatic t_reset_keeps();
        set_a(1'b1, 1'b0, 10'd20, 9'h000); cyc();
        a_rst_n = 1'b0; cyc();
        chk("R11 reset drops drive", {a_drive, a_dout}, '0);
        a_rst_n = 1'b1; cyc();
        chk("R11 array kept across reset", {a_drive, a_dout}, {1'b1, 9'h0F0});
        idle_both(); cyc();
    endtask

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        #200000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset();
        t_flow_rw();
        t_write_quiet();
        t_oe();
        t_select();
        t_pipe();
        t_cross();
        t_parallel();
        t_collide();
        t_reset_keeps();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule